// File: doc/BRIEF.md
# Instruction Cache Miss Holding Entry

This block tracks one outstanding line miss for a read-only instruction cache. The fetch or prefetch pipeline hands it a line address, the one-hot way chosen by the replacement unit, a flag that says whether the miss came from a prefetch, and a poison bit for error injection. The entry then raises a block read on an abstract request channel. Once the request is taken, it gathers a two-beat grant on the response channel. In the cycle the final beat arrives, it produces two things: a single-cycle array write carrying the line, its tag and its parity bits, and a single-cycle response to the requester.

Flush and fence have the same effect on the entry. If the request has not yet been accepted, the entry is dropped at once. If the request is already out, the entry stays busy with a pending-kill mark, absorbs the grant and produces nothing. A kill that arrives in the same cycle as the final beat still lets the response out, but it blocks the array write. A grant marked corrupt on any beat turns the response into an access fault and blocks the write.

Top module: `missEntry`

## Requirements
- R1: After reset the entry is idle: `allocReady` is 1, and `busReqValid`, `arrWrite` and `respValid` are 0.
- R2: An allocation is accepted when `allocValid` and `allocReady` are both 1. From the next cycle `busReqValid` is 1 with `busReqLine` equal to the allocated line address, and both hold steady until `busReqReady`. `allocReady` stays 0 until the cycle after completion.
- R3: A flush or fence during a cycle in which the request is valid but not accepted drops the entry. The next cycle shows `allocReady`=1 and `busReqValid`=0, and grant beats that arrive later produce no write and no response.
- R4: A flush or fence after the request is accepted (including in the acceptance cycle itself) keeps the entry busy until the final beat. It then returns to idle with no array write and no response.
- R5: A flush or fence in the same cycle as the final beat, with no earlier kill, still gives `respValid`=1 with the line, but `arrWrite`=0.
- R6: Beat 0 fills line bits 255:0 and beat 1 fills bits 511:256. `arrWrite` and `respValid` are combinational pulses in the cycle of the last beat and last exactly one cycle.
- R7: `arrDataCode[i]` is the XOR of line bits 64*i+63 down to 64*i, XORed with the poison bit captured at allocation.
- R8: The array write carries `arrSet` = line address bits 7:0, `arrTag` = line address bits 41:8, `arrWay` = the allocated way mask, and `arrMetaCode` = XOR of all tag bits XORed with the poison bit.
- R9: With poison set at allocation, all eight data parity bits and the metadata parity bit are inverted relative to their unpoisoned values.
- R10: If `grantCorrupt` is 1 on any beat of the grant, `respFault` is 1 with the response and `arrWrite` is 0.
- R11: The response carries `respLine` = the allocated line address and `respIsPrefetch` = the allocated prefetch flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| allocValid | input | 1 | Allocation request |
| allocReady | output | 1 | Entry is idle and can accept an allocation |
| allocLine | input | 42 | Line address of the miss |
| allocWay | input | 4 | One-hot way to fill |
| allocIsPrefetch | input | 1 | Miss came from a prefetch |
| allocPoison | input | 1 | Invert all written parity bits |
| flush | input | 1 | Pipeline flush |
| fence | input | 1 | Instruction fence |
| busReqValid | output | 1 | Block read request valid |
| busReqReady | input | 1 | Request channel accepts |
| busReqLine | output | 42 | Requested line address |
| grantValid | input | 1 | Grant beat valid |
| grantData | input | 256 | Grant beat data |
| grantCorrupt | input | 1 | Beat is corrupt or denied |
| arrWrite | output | 1 | Array write pulse |
| arrSet | output | 8 | Set index to write |
| arrTag | output | 34 | Tag to write |
| arrWay | output | 4 | Way mask to write |
| arrData | output | 512 | Line data to write |
| arrDataCode | output | 8 | Data parity bits |
| arrMetaCode | output | 1 | Tag parity bit |
| respValid | output | 1 | Response pulse to requester |
| respLine | output | 42 | Response line address |
| respIsPrefetch | output | 1 | Response belongs to a prefetch |
| respData | output | 512 | Response line data |
| respFault | output | 1 | Access fault on the line |

## Verification
The request appears one cycle after an allocation is accepted, and a kill before acceptance shows up as idle one cycle later. Both the array write and the response are combinational with the last grant beat, so they are due in that same cycle. The bench drives every input just after a falling edge and samples a few time units later, still before the next rising edge. The driver queues the expected write and response before it drives the last beat, and the monitor compares them in that same cycle. Any write or response that appears with nothing queued is reported, which is how the dropped and draining entries of R3 and R4 are checked.

// File: rtl/missPkg.sv
package missPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } missState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // load allocation fields
    logic beatLoad;  // shift a non-final beat into the buffer
  } missStrobe_t;

endpackage

// File: rtl/missParity.sv
module missParity #(
  parameter int UNITS     = 8,
  parameter int UNIT_BITS = 64
) (
  input  logic [UNITS*UNIT_BITS-1:0] din,
  input  logic                       poison,
  output logic [UNITS-1:0]           code
);

  for (genvar u = 0; u < UNITS; u++) begin : gUnit
    assign code[u] = (^din[u*UNIT_BITS +: UNIT_BITS]) ^ poison;
  end

endmodule

// File: rtl/missCtrl.sv
module missCtrl
  import missPkg::*;
#(
  parameter int BEATS = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        allocValid,
  input  logic        busReqReady,
  input  logic        grantValid,
  input  logic        flush,
  input  logic        fence,
  input  logic        faultNow,
  output logic        allocReady,
  output logic        busReqValid,
  output logic        arrWrite,
  output logic        respValid,
  output missStrobe_t strobe
);

  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  missState_t        stateQ, stateD;
  logic              pendingQ, pendingD;
  logic [BEAT_W-1:0] beatQ, beatD;
  logic              kill, reqFire, grantLast;

  assign kill        = flush | fence;
  assign allocReady  = (stateQ == ST_IDLE);
  assign busReqValid = (stateQ == ST_REQ);
  assign reqFire     = busReqValid & busReqReady;
  assign grantLast   = (stateQ == ST_WAIT) & grantValid & (beatQ == LAST_BEAT);

  assign strobe.capture  = allocValid & allocReady;
  assign strobe.beatLoad = (stateQ == ST_WAIT) & grantValid & (beatQ != LAST_BEAT);

  // completion pulses: a pending kill silences everything,
  // a kill on the last beat or a corrupt grant only blocks the write
  assign respValid = grantLast & ~pendingQ;
  assign arrWrite  = grantLast & ~pendingQ & ~kill & ~faultNow;

  always_comb begin
    stateD   = stateQ;
    pendingD = pendingQ;
    beatD    = beatQ;
    unique case (stateQ)
      ST_IDLE: begin
        pendingD = 1'b0;
        beatD    = '0;
        if (strobe.capture) stateD = ST_REQ;
      end
      ST_REQ: begin
        if (reqFire) begin
          stateD   = ST_WAIT;
          pendingD = kill;
        end else if (kill) begin
          stateD = ST_IDLE;
        end
      end
      ST_WAIT: begin
        pendingD = pendingQ | kill;
        if (grantValid) begin
          if (beatQ == LAST_BEAT) begin
            stateD   = ST_IDLE;
            pendingD = 1'b0;
            beatD    = '0;
          end else begin
            beatD = beatQ + 1'b1;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      pendingQ <= 1'b0;
      beatQ    <= '0;
    end else begin
      stateQ   <= stateD;
      pendingQ <= pendingD;
      beatQ    <= beatD;
    end
  end

  // R3: kill before the request is taken drops the entry
  a_r3_kill_before_issue: assert property (@(posedge clk) disable iff (!rstN)
    (busReqValid && !busReqReady && (flush || fence)) |=> allocReady);

  // R5: kill on the completing beat blocks the write
  a_r5_kill_on_last_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && (flush || fence)) |-> !arrWrite);

  // R6: response is a one-cycle pulse
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid);

  // R2: busy while a request is outstanding, idle after completion
  a_r2_busy_in_req: assert property (@(posedge clk) disable iff (!rstN)
    busReqValid |-> !allocReady);
  a_r2_idle_after_resp: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> allocReady);

endmodule

// File: rtl/missData.sv
module missData
  import missPkg::*;
#(
  parameter int LINE_ADDR_BITS = 42,
  parameter int SET_BITS       = 8,
  parameter int WAYS           = 4,
  parameter int LINE_BITS      = 512,
  parameter int BEAT_BITS      = 256,
  parameter int UNIT_BITS      = 64,
  localparam int BEATS         = LINE_BITS / BEAT_BITS,
  localparam int UNITS         = LINE_BITS / UNIT_BITS,
  localparam int TAG_BITS      = LINE_ADDR_BITS - SET_BITS
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  missStrobe_t               strobe,
  input  logic [LINE_ADDR_BITS-1:0] allocLine,
  input  logic [WAYS-1:0]           allocWay,
  input  logic                      allocIsPrefetch,
  input  logic                      allocPoison,
  input  logic [BEAT_BITS-1:0]      grantData,
  input  logic                      grantCorrupt,
  output logic [LINE_ADDR_BITS-1:0] lineAddr,
  output logic [SET_BITS-1:0]       setIdx,
  output logic [TAG_BITS-1:0]       tagBits,
  output logic [WAYS-1:0]           wayMask,
  output logic                      isPrefetch,
  output logic [LINE_BITS-1:0]      lineData,
  output logic [UNITS-1:0]          dataCode,
  output logic                      metaCode,
  output logic                      faultNow
);

  localparam int BUF_BITS = (BEATS - 1) * BEAT_BITS;

  logic [LINE_ADDR_BITS-1:0] lineQ;
  logic [WAYS-1:0]           wayQ;
  logic                      pfQ, poisonQ, faultQ;
  logic [BUF_BITS-1:0]       bufQ, bufShift;

  // earlier beats shift down so beat 0 ends at the low end
  if (BEATS > 2) begin : gWideBuf
    assign bufShift = {grantData, bufQ[BUF_BITS-1:BEAT_BITS]};
  end else begin : gOneBuf
    assign bufShift = grantData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineQ   <= '0;
      wayQ    <= '0;
      pfQ     <= 1'b0;
      poisonQ <= 1'b0;
      faultQ  <= 1'b0;
      bufQ    <= '0;
    end else begin
      if (strobe.capture) begin
        lineQ   <= allocLine;
        wayQ    <= allocWay;
        pfQ     <= allocIsPrefetch;
        poisonQ <= allocPoison;
        faultQ  <= 1'b0;
      end
      if (strobe.beatLoad) begin
        bufQ   <= bufShift;
        faultQ <= faultQ | grantCorrupt;
      end
    end
  end

  assign lineData   = {grantData, bufQ};
  assign faultNow   = faultQ | grantCorrupt;
  assign lineAddr   = lineQ;
  assign setIdx     = lineQ[SET_BITS-1:0];
  assign tagBits    = lineQ[LINE_ADDR_BITS-1:SET_BITS];
  assign wayMask    = wayQ;
  assign isPrefetch = pfQ;

  missParity #(.UNITS(UNITS), .UNIT_BITS(UNIT_BITS)) uDataPar (
    .din    (lineData),
    .poison (poisonQ),
    .code   (dataCode)
  );

  missParity #(.UNITS(1), .UNIT_BITS(TAG_BITS)) uMetaPar (
    .din    (tagBits),
    .poison (poisonQ),
    .code   (metaCode)
  );

  // R10: a corrupt beat keeps the fault visible until completion
  a_r10_fault_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.beatLoad && grantCorrupt) |=> faultNow);

endmodule

// File: rtl/missEntry.sv
module missEntry
  import missPkg::*;
#(
  parameter int LINE_ADDR_BITS = 42,
  parameter int SET_BITS       = 8,
  parameter int WAYS           = 4,
  parameter int LINE_BITS      = 512,
  parameter int BEAT_BITS      = 256,
  parameter int UNIT_BITS      = 64,
  localparam int UNITS         = LINE_BITS / UNIT_BITS,
  localparam int TAG_BITS      = LINE_ADDR_BITS - SET_BITS
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      allocValid,
  output logic                      allocReady,
  input  logic [LINE_ADDR_BITS-1:0] allocLine,
  input  logic [WAYS-1:0]           allocWay,
  input  logic                      allocIsPrefetch,
  input  logic                      allocPoison,
  input  logic                      flush,
  input  logic                      fence,
  output logic                      busReqValid,
  input  logic                      busReqReady,
  output logic [LINE_ADDR_BITS-1:0] busReqLine,
  input  logic                      grantValid,
  input  logic [BEAT_BITS-1:0]      grantData,
  input  logic                      grantCorrupt,
  output logic                      arrWrite,
  output logic [SET_BITS-1:0]       arrSet,
  output logic [TAG_BITS-1:0]       arrTag,
  output logic [WAYS-1:0]           arrWay,
  output logic [LINE_BITS-1:0]      arrData,
  output logic [UNITS-1:0]          arrDataCode,
  output logic                      arrMetaCode,
  output logic                      respValid,
  output logic [LINE_ADDR_BITS-1:0] respLine,
  output logic                      respIsPrefetch,
  output logic [LINE_BITS-1:0]      respData,
  output logic                      respFault
);

  missStrobe_t               strobe;
  logic                      faultNow;
  logic [LINE_ADDR_BITS-1:0] lineAddr;
  logic [LINE_BITS-1:0]      lineData;

  missCtrl #(.BEATS(LINE_BITS / BEAT_BITS)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .allocValid  (allocValid),
    .busReqReady (busReqReady),
    .grantValid  (grantValid),
    .flush       (flush),
    .fence       (fence),
    .faultNow    (faultNow),
    .allocReady  (allocReady),
    .busReqValid (busReqValid),
    .arrWrite    (arrWrite),
    .respValid   (respValid),
    .strobe      (strobe)
  );

  missData #(
    .LINE_ADDR_BITS (LINE_ADDR_BITS),
    .SET_BITS       (SET_BITS),
    .WAYS           (WAYS),
    .LINE_BITS      (LINE_BITS),
    .BEAT_BITS      (BEAT_BITS),
    .UNIT_BITS      (UNIT_BITS)
  ) uData (
    .clk             (clk),
    .rstN            (rstN),
    .strobe          (strobe),
    .allocLine       (allocLine),
    .allocWay        (allocWay),
    .allocIsPrefetch (allocIsPrefetch),
    .allocPoison     (allocPoison),
    .grantData       (grantData),
    .grantCorrupt    (grantCorrupt),
    .lineAddr        (lineAddr),
    .setIdx          (arrSet),
    .tagBits         (arrTag),
    .wayMask         (arrWay),
    .isPrefetch      (respIsPrefetch),
    .lineData        (lineData),
    .dataCode        (arrDataCode),
    .metaCode        (arrMetaCode),
    .faultNow        (faultNow)
  );

  assign busReqLine = lineAddr;
  assign respLine   = lineAddr;
  assign arrData    = lineData;
  assign respData   = lineData;
  assign respFault  = faultNow;

  // R2: an unaccepted request holds with a stable address
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busReqValid && !busReqReady && !flush && !fence) |=> (busReqValid && $stable(busReqLine)));

  // R4: a write never occurs without a response
  a_r4_write_needs_resp: assert property (@(posedge clk) disable iff (!rstN)
    arrWrite |-> respValid);

  // R10: a faulty line is never written
  a_r10_fault_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respFault) |-> !arrWrite);

  // R1: idle and requesting are exclusive
  a_r1_ready_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(allocReady && busReqValid));

endmodule

// File: tb/tb_missEntry.sv
module tb_missEntry;

  localparam int LA = 42;
  localparam int SB = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic           allocValid = 0, allocIsPrefetch = 0, allocPoison = 0;
  logic [LA-1:0]  allocLine = '0;
  logic [3:0]     allocWay = '0;
  logic           flush = 0, fence = 0, busReqReady = 0;
  logic           grantValid = 0, grantCorrupt = 0;
  logic [255:0]   grantData = '0;
  logic           allocReady, busReqValid, arrWrite, arrMetaCode;
  logic           respValid, respIsPrefetch, respFault;
  logic [LA-1:0]  busReqLine, respLine;
  logic [SB-1:0]  arrSet;
  logic [LA-SB-1:0] arrTag;
  logic [3:0]     arrWay;
  logic [511:0]   arrData, respData;
  logic [7:0]     arrDataCode;

  missEntry dut (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocReady(allocReady),
    .allocLine(allocLine), .allocWay(allocWay), .allocIsPrefetch(allocIsPrefetch),
    .allocPoison(allocPoison), .flush(flush), .fence(fence),
    .busReqValid(busReqValid), .busReqReady(busReqReady), .busReqLine(busReqLine),
    .grantValid(grantValid), .grantData(grantData), .grantCorrupt(grantCorrupt),
    .arrWrite(arrWrite), .arrSet(arrSet), .arrTag(arrTag), .arrWay(arrWay),
    .arrData(arrData), .arrDataCode(arrDataCode), .arrMetaCode(arrMetaCode),
    .respValid(respValid), .respLine(respLine), .respIsPrefetch(respIsPrefetch),
    .respData(respData), .respFault(respFault)
  );

  typedef struct {
    logic          expWrite;
    logic [LA-1:0] line;
    logic [3:0]    way;
    logic          pf;
    logic          fault;
    logic [511:0]  data;
    logic [7:0]    dcode;
    logic          mcode;
  } exp_t;

  exp_t expQ[$];
  int nChecks = 0;
  int nFails  = 0;

  task automatic check(string tag, logic [511:0] act, logic [511:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dataCodes(logic [511:0] d, logic p);
    logic [7:0] c;
    for (int i = 0; i < 8; i++) c[i] = (^d[i*64 +: 64]) ^ p;
    return c;
  endfunction

  // monitor: every write or response must match a queued expectation
  always @(negedge clk) begin
    #2;
    if (rstN && (respValid || arrWrite)) begin
      if (expQ.size() == 0) begin
        check("R3/R4 unexpected output", {respValid, arrWrite}, 2'b00);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check("R6 respValid", respValid, 1'b1);
        check("R5/R10 arrWrite", arrWrite, e.expWrite);
        check("R6 respData", respData, e.data);
        check("R11 respLine", respLine, e.line);
        check("R11 respIsPrefetch", respIsPrefetch, e.pf);
        check("R10 respFault", respFault, e.fault);
        if (e.expWrite) begin
          check("R6 arrData", arrData, e.data);
          check("R8 arrSet", arrSet, e.line[SB-1:0]);
          check("R8 arrTag", arrTag, e.line[LA-1:SB]);
          check("R8 arrWay", arrWay, e.way);
          check("R7/R9 arrDataCode", arrDataCode, e.dcode);
          check("R8/R9 arrMetaCode", arrMetaCode, e.mcode);
        end
      end
    end
  end

  task automatic setKill(bit useFence, logic v);
    if (useFence) fence = v; else flush = v;
  endtask

  // mode: 0 none, 1 kill before issue, 2 kill while waiting,
  //       3 kill on last beat, 4 kill on request acceptance
  task automatic doMiss(logic [LA-1:0] line, logic [3:0] way, logic pf, logic psn,
                        logic [255:0] d0, logic [255:0] d1, int corruptBeat,
                        int mode, int reqDelay, bit useFence);
    logic [511:0] full;
    full = {d1, d0};
    @(negedge clk);
    allocValid = 1; allocLine = line; allocWay = way;
    allocIsPrefetch = pf; allocPoison = psn;
    #1 check("R2 allocReady idle", allocReady, 1'b1);
    @(negedge clk);
    allocValid = 0; allocLine = '0; allocWay = '0; allocIsPrefetch = 0; allocPoison = 0;
    #1;
    check("R2 busReqValid", busReqValid, 1'b1);
    check("R2 busReqLine", busReqLine, line);
    check("R2 allocReady busy", allocReady, 1'b0);
    if (mode == 1) begin
      setKill(useFence, 1'b1);
      @(negedge clk);
      setKill(useFence, 1'b0);
      #1;
      check("R3 idle after kill", allocReady, 1'b1);
      check("R3 request dropped", busReqValid, 1'b0);
      @(negedge clk); grantValid = 1; grantData = d0;
      @(negedge clk); grantData = d1;
      @(negedge clk); grantValid = 0;
      #1 check("R3 still idle", allocReady, 1'b1);
      return;
    end
    for (int k = 0; k < reqDelay; k++) begin
      @(negedge clk);
      #1;
      check("R2 request held", busReqValid, 1'b1);
      check("R2 line stable", busReqLine, line);
    end
    @(negedge clk);
    busReqReady = 1;
    if (mode == 4) setKill(useFence, 1'b1);
    @(negedge clk);
    busReqReady = 0;
    setKill(useFence, 1'b0);
    #1;
    check("R2 request gone", busReqValid, 1'b0);
    check("R2 busy in wait", allocReady, 1'b0);
    if (mode == 2) begin
      @(negedge clk); setKill(useFence, 1'b1);
      @(negedge clk); setKill(useFence, 1'b0);
    end
    @(negedge clk);
    grantValid = 1; grantData = d0; grantCorrupt = (corruptBeat == 1);
    @(negedge clk);
    if (mode != 2 && mode != 4) begin
      exp_t e;
      e.expWrite = (mode != 3) && (corruptBeat == 0);
      e.line = line; e.way = way; e.pf = pf;
      e.fault = (corruptBeat != 0);
      e.data = full;
      e.dcode = dataCodes(full, psn);
      e.mcode = (^line[LA-1:SB]) ^ psn;
      expQ.push_back(e);
    end
    grantData = d1; grantCorrupt = (corruptBeat == 2);
    if (mode == 3) setKill(useFence, 1'b1);
    @(negedge clk);
    grantValid = 0; grantCorrupt = 0; grantData = '0;
    setKill(useFence, 1'b0);
    #1;
    check("R2/R4 idle after grant", allocReady, 1'b1);
    check("R6 single pulse", respValid, 1'b0);
  endtask

  initial begin
    #200000;
    nFails++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 reset allocReady", allocReady, 1'b1);
    check("R1 reset busReqValid", busReqValid, 1'b0);
    check("R1 reset respValid", respValid, 1'b0);
    check("R1 reset arrWrite", arrWrite, 1'b0);
    rstN = 1;
    // R6 R7 R8 R11 plain fetch miss
    doMiss(42'h123_4567_89AB, 4'b0010, 0, 0,
           {4{64'h0123_4567_89AB_CDEF}}, {4{64'hFEDC_BA98_7654_3211}}, 0, 0, 0, 0);
    // R2 R9 prefetch with held request and poison
    doMiss(42'h2AA_5555_0F0F, 4'b1000, 1, 1,
           {64'h1, 64'h3, 64'h7, 64'h0}, {64'hF, 64'h0, 64'hFF, 64'h8000_0000_0000_0001}, 0, 0, 3, 0);
    // R3 flush and fence before issue
    doMiss(42'h001_0000_0001, 4'b0001, 0, 0, {4{64'hAAAA}}, {4{64'hBBBB}}, 0, 1, 0, 0);
    doMiss(42'h002_0000_0002, 4'b0001, 1, 0, {4{64'hCCCC}}, {4{64'hDDDD}}, 0, 1, 1, 1);
    // R4 kill while waiting and on acceptance
    doMiss(42'h003_0000_0003, 4'b0100, 0, 0, {4{64'h1111}}, {4{64'h2222}}, 0, 2, 0, 1);
    doMiss(42'h004_0000_0004, 4'b0100, 1, 0, {4{64'h3333}}, {4{64'h4444}}, 0, 4, 2, 0);
    // R5 kill on last beat, flush and fence
    doMiss(42'h3FF_FFFF_FF00, 4'b0010, 0, 0, {4{64'h5A5A}}, {4{64'hA5A4}}, 0, 3, 0, 0);
    doMiss(42'h155_1234_5678, 4'b1000, 1, 1, {4{64'h7}}, {4{64'h6}}, 0, 3, 1, 1);
    // R10 corrupt on either beat
    doMiss(42'h0AB_CDEF_0123, 4'b0001, 0, 0, {4{64'h99}}, {4{64'h98}}, 1, 0, 0, 0);
    doMiss(42'h0AB_CDEF_0124, 4'b0010, 1, 0, {4{64'h97}}, {4{64'h96}}, 2, 0, 1, 0);
    // R6 R7 recovery after kills
    doMiss(42'h0F0_F0F0_F0F0, 4'b0100, 0, 0,
           {64'hDEAD_BEEF_0000_0001, 64'h0, 64'h1, 64'h3}, {4{64'hFFFF_FFFF_FFFF_FFFF}}, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check("R4 expectation queue drained", expQ.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule